// File: doc/BRIEF.md
# Self-Checking OLS Syndrome Generator

This block forms the syndrome of a single-error-correcting Orthogonal Latin Squares code read back from storage. It takes the data word (m squared bits, 16 by default) and the stored check bits (2m, 8 by default). It recomputes every parity check from the data and XORs each one with its stored check bit. Each syndrome bit is 1 where the recomputed check disagrees with the stored one.

Because every data bit feeds exactly two checks, the XOR of all syndrome bits must equal the XOR of all stored check bits for any read word, whether or not it holds storage errors. The block computes these two parities on separate XOR trees, the two rails. Their difference is a fault flag that rises only when the syndrome logic itself is faulty. When the flag is set, the output takes the syndrome from a second, independently built syndrome network driven by the same inputs.

A per-data-bit locator marks the bit whose two checks both fire, for use by a downstream corrector. An injection mask, XORed onto the primary syndrome, lets a test environment emulate internal faults. The block is purely combinational.

Top module: `ols_syndrome_selfcheck`

## Requirements
- R1: For each group g in 0..m-1, syndrome bit g equals stored check bit g XOR the parity of data bits m*g through m*g+m-1.
- R2: For each column c in 0..m-1, syndrome bit m+c equals stored check bit m+c XOR the parity of data bits c, c+m, c+2m and so on up to c+(m-1)m.
- R3: rail_a is the XOR of the primary syndrome bits (after injection), rail_b is the XOR of the stored check bits, and flag_f is rail_a XOR rail_b. With a zero injection mask, flag_f is 0 for every read word, including words with any number of storage errors.
- R4: A fault mask with exactly one bit set forces flag_f to 1 for every read word.
- R5: When flag_f is 1, syn_out equals the true syndrome given by R1 and R2, produced by the duplicate network.
- R6: When flag_f is 0, syn_out is the primary syndrome. A clean codeword (check bits consistent with the data) gives an all-zero syn_out.
- R7: bit_flag[j] is 1 exactly when syn_out[j/m] and syn_out[m + j mod m] are both 1. A single data error at bit j sets only bit_flag[j].
- R8: A single error in stored check bit i makes syn_out one-hot at bit i and leaves bit_flag all zero.
- R9: Two data-bit errors leave flag_f at 0 and syn_out equal to the R1/R2 syndrome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 16 | Data bits read from storage |
| chk_in | input | 8 | Check bits read from storage |
| fault_inj | input | 8 | Fault mask XORed onto the primary syndrome |
| syn_out | output | 8 | Selected syndrome |
| flag_f | output | 1 | Internal fault flag, rail_a XOR rail_b |
| rail_a | output | 1 | Parity of the primary syndrome |
| rail_b | output | 1 | Parity of the stored check bits |
| bit_flag | output | 16 | Per-data-bit error marks derived from syn_out |

## Verification
Every output is combinational, so each result is due in the same cycle its inputs are applied, with no register between input and output. The bench drives inputs just after a falling edge, lets them settle through the following rising edge, and samples one time unit later. No result therefore depends on the order of events at an edge. All expected syndromes, locator flags and rail values come from a behavioural model of the row masks written in the bench.

// File: rtl/ols_syn_pkg.sv
package ols_syn_pkg;

  localparam int unsigned MASK_W = 256;

  // membership of data bits in parity row r for an OLS code of order m
  function automatic logic [MASK_W-1:0] row_mask(int unsigned m, int unsigned r);
    logic [MASK_W-1:0] msk;
    msk = '0;
    for (int unsigned j = 0; j < m * m; j++) begin
      if (r < m) msk[j] = ((j / m) == r);
      else       msk[j] = ((j % m) == (r - m));
    end
    return msk;
  endfunction

endpackage

// File: rtl/ols_syn_net.sv
module ols_syn_net #(
  parameter int unsigned M = 4,
  localparam int unsigned K = M * M,
  localparam int unsigned R = 2 * M
) (
  input  logic [K-1:0] data_i,
  input  logic [R-1:0] chk_i,
  output logic [R-1:0] syn_o
);

  for (genvar r = 0; r < R; r++) begin : g_row
    localparam logic [ols_syn_pkg::MASK_W-1:0] FULL = ols_syn_pkg::row_mask(M, r);
    localparam logic [K-1:0] MSK = FULL[K-1:0];
    assign syn_o[r] = chk_i[r] ^ (^(data_i & MSK));
  end

endmodule

// File: rtl/ols_xor_fold.sv
module ols_xor_fold #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic         par_o
);

  logic [W-1:0] chain;

  assign chain[0] = vec_i[0];
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign chain[i] = chain[i-1] ^ vec_i[i];
  end
  assign par_o = chain[W-1];

endmodule

// File: rtl/ols_bit_locator.sv
module ols_bit_locator #(
  parameter int unsigned M = 4,
  localparam int unsigned K = M * M,
  localparam int unsigned R = 2 * M
) (
  input  logic [R-1:0] syn_i,
  output logic [K-1:0] flag_o
);

  for (genvar j = 0; j < K; j++) begin : g_bit
    assign flag_o[j] = syn_i[j / M] & syn_i[M + (j % M)];
  end

endmodule

// File: rtl/ols_syndrome_selfcheck.sv
module ols_syndrome_selfcheck #(
  parameter int unsigned M = 4,
  localparam int unsigned K = M * M,
  localparam int unsigned R = 2 * M
) (
  input  logic [K-1:0] data_in,
  input  logic [R-1:0] chk_in,
  input  logic [R-1:0] fault_inj,
  output logic [R-1:0] syn_out,
  output logic         flag_f,
  output logic         rail_a,
  output logic         rail_b,
  output logic [K-1:0] bit_flag
);

  logic [R-1:0] prim_raw;
  logic [R-1:0] prim_syn;
  logic [R-1:0] dup_syn;

  ols_syn_net #(.M(M)) u_prim (
    .data_i (data_in),
    .chk_i  (chk_in),
    .syn_o  (prim_raw)
  );

  ols_syn_net #(.M(M)) u_dup (
    .data_i (data_in),
    .chk_i  (chk_in),
    .syn_o  (dup_syn)
  );

  assign prim_syn = prim_raw ^ fault_inj;

  ols_xor_fold #(.W(R)) u_rail_syn (
    .vec_i (prim_syn),
    .par_o (rail_a)
  );

  ols_xor_fold #(.W(R)) u_rail_chk (
    .vec_i (chk_in),
    .par_o (rail_b)
  );

  always_comb begin
    flag_f  = rail_a ^ rail_b;
    syn_out = flag_f ? dup_syn : prim_syn;
  end

  ols_bit_locator #(.M(M)) u_loc (
    .syn_i  (syn_out),
    .flag_o (bit_flag)
  );

  always_comb begin
    if (!$isunknown({data_in, chk_in, fault_inj})) begin
      if (fault_inj == '0)
        AST_RAILS_AGREE: assert (rail_a == rail_b) else $error("rails differ without fault"); // R3
      if ($countones(fault_inj) == 1)
        AST_FAULT_RAISES_FLAG: assert (flag_f) else $error("single fault not flagged"); // R4
      if (flag_f)
        AST_DUP_SELECTED: assert (syn_out == dup_syn) else $error("duplicate not selected"); // R5
      if ($countones(syn_out) <= 2)
        AST_LOCATOR_ONEHOT: assert ($onehot0(bit_flag)) else $error("locator not one-hot"); // R7
    end
  end

endmodule

// File: tb/tb_ols_syndrome_selfcheck.sv
`timescale 1ns/1ps
module tb_ols_syndrome_selfcheck;

  localparam int unsigned M = 4;
  localparam int unsigned K = M * M;
  localparam int unsigned R = 2 * M;

  logic         clk;
  logic         rst_n;
  logic [K-1:0] data_in;
  logic [R-1:0] chk_in;
  logic [R-1:0] fault_inj;
  logic [R-1:0] syn_out;
  logic         flag_f;
  logic         rail_a;
  logic         rail_b;
  logic [K-1:0] bit_flag;

  int n_chk;
  int n_bad;
  bit finished;

  ols_syndrome_selfcheck #(.M(M)) dut (
    .data_in   (data_in),
    .chk_in    (chk_in),
    .fault_inj (fault_inj),
    .syn_out   (syn_out),
    .flag_f    (flag_f),
    .rail_a    (rail_a),
    .rail_b    (rail_b),
    .bit_flag  (bit_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [R-1:0] enc(logic [K-1:0] d);
    logic [R-1:0] c;
    c = '0;
    for (int g = 0; g < M; g++)
      for (int i = 0; i < M; i++) begin
        c[g]     = c[g]     ^ d[g*M + i];
        c[M + g] = c[M + g] ^ d[i*M + g];
      end
    return c;
  endfunction

  function automatic logic [R-1:0] ref_syn(logic [K-1:0] d, logic [R-1:0] c);
    return enc(d) ^ c;
  endfunction

  function automatic logic [K-1:0] ref_loc(logic [R-1:0] s);
    logic [K-1:0] f;
    for (int j = 0; j < K; j++) f[j] = s[j / M] & s[M + (j % M)];
    return f;
  endfunction

  task automatic apply(logic [K-1:0] d, logic [R-1:0] c, logic [R-1:0] fm);
    @(negedge clk);
    data_in   = d;
    chk_in    = c;
    fault_inj = fm;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [K-1:0] d, logic [R-1:0] c, logic [R-1:0] fm);
    logic [R-1:0] s;
    s = ref_syn(d, c);
    check({req, " syn"},  32'(syn_out),  32'(s));
    check({req, " flag"}, 32'(flag_f),   32'($countones(fm) % 2));
    check({req, " railb"}, 32'(rail_b),  32'(^c));
    check({req, " loc"},  32'(bit_flag), 32'(ref_loc(s)));
  endtask

  task automatic t_reset_state;
    apply('0, '0, '0);
    check("R6 zero word syn", 32'(syn_out), 32'(0));
    check("R3 zero word flag", 32'(flag_f), 32'(0));
    check("R7 zero word loc", 32'(bit_flag), 32'(0));
  endtask

  task automatic t_clean;
    for (int n = 0; n < 8; n++) begin
      logic [K-1:0] d;
      d = K'($urandom);
      apply(d, enc(d), '0);
      check("R6 clean syn", 32'(syn_out), 32'(0));
      check("R3 clean flag", 32'(flag_f), 32'(0));
    end
  endtask

  task automatic t_single_data;
    for (int j = 0; j < K; j++) begin
      logic [K-1:0] d;
      d = K'($urandom);
      apply(d ^ (K'(1) << j), enc(d), '0);
      check("R1 group bit", 32'(syn_out[j / M]), 32'(1));
      check("R2 column bit", 32'(syn_out[M + j % M]), 32'(1));
      check("R7 single data loc", 32'(bit_flag), 32'(K'(1) << j));
    end
  endtask

  task automatic t_single_chk;
    for (int i = 0; i < R; i++) begin
      logic [K-1:0] d;
      d = K'($urandom);
      apply(d, enc(d) ^ (R'(1) << i), '0);
      check("R8 chk err syn", 32'(syn_out), 32'(R'(1) << i));
      check("R8 chk err loc", 32'(bit_flag), 32'(0));
      check("R3 chk err flag", 32'(flag_f), 32'(0));
    end
  endtask

  task automatic t_double;
    for (int n = 0; n < 16; n++) begin
      logic [K-1:0] d;
      logic [K-1:0] e;
      int a;
      int b;
      a = int'($urandom % K);
      b = (a + 1 + int'($urandom % (K - 1))) % K;
      e = (K'(1) << a) | (K'(1) << b);
      d = K'($urandom);
      apply(d ^ e, enc(d), '0);
      check_all("R9 double", d ^ e, enc(d), '0);
    end
  endtask

  task automatic t_fault;
    for (int i = 0; i < R; i++) begin
      logic [K-1:0] d;
      logic [R-1:0] c;
      d = K'($urandom);
      c = enc(d) ^ ((i % 2 == 0) ? R'(0) : R'(1) << ((i + 3) % R));
      apply(d ^ K'(i), c, R'(1) << i);
      check("R4 fault flag", 32'(flag_f), 32'(1));
      check("R5 fault syn", 32'(syn_out), 32'(ref_syn(d ^ K'(i), c)));
      check("R3 fault rails", 32'(rail_a ^ rail_b), 32'(1));
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 48; n++) begin
      logic [K-1:0] d;
      logic [R-1:0] c;
      d = K'($urandom);
      c = R'($urandom);
      apply(d, c, '0);
      check_all("R1 R2 R3 random", d, c, '0);
      check("R3 rail a", 32'(rail_a), 32'(^ref_syn(d, c)));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    data_in   = '0;
    chk_in    = '0;
    fault_inj = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state;
    t_clean;
    t_single_data;
    t_single_chk;
    t_double;
    t_fault;
    t_random;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule